// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations. A lookup presents a 48-bit virtual address. The upper 36 bits form the virtual page number (VPN) and the low 12 bits are the page offset. The lookup is combinational. In the same cycle the block reports either a hit, with a 52-bit physical address, or a miss. On a miss, an external page walker later supplies the translation through the refill port, and that write takes effect at the next clock edge.

Storage is organised as 16 sets of 4 ways. The low 4 bits of the VPN pick the set, and the remaining 32 bits are kept as the tag. Each way holds a valid flag, a tag and a 40-bit physical page number. Entries are only ever filled from outside and never written back, so no line carries a modified flag.

Within a set, a refill first reuses a way that already holds the same tag. Failing that, it takes the lowest-numbered empty way. When the set is full, a per-set rotating pointer picks the way to replace. A pulse on the kernel-entry input empties the whole buffer in one cycle.

Top module: `tlb_sa`

## Requirements
- R1: After reset every entry is empty, so every lookup with `lk_valid` high reports a miss.
- R2: A lookup hits only when the set selected by VPN bits [3:0] holds a valid way whose tag equals VPN bits [35:4]. On a hit, `lk_paddr` is the stored 40-bit page number in bits [51:12], followed by `lk_vaddr[11:0]` in bits [11:0].
- R3: With `lk_valid` high, exactly one of `lk_hit` and `lk_miss` is high. With `lk_valid` low, both are low.
- R4: A refill accepted at one clock edge makes a lookup of the same VPN in the next cycle hit, returning the refilled page number.
- R5: Sets are independent. Two VPNs with the same tag but different set bits occupy separate entries and return their own page numbers.
- R6: A refill whose tag is not present goes to the lowest-numbered empty way of its set. Filling an empty way does not move the set's rotating pointer.
- R7: A refill into a full set replaces the way named by that set's rotating pointer. The pointer starts at 0, advances by one modulo 4 after each such replacement, and is not changed by invalidation.
- R8: A refill whose tag already sits valid in its set overwrites that way in place. The other ways keep their contents and the rotating pointer does not move.
- R9: A cycle with `kmode_enter` high empties every entry at the clock edge. All later lookups miss until new refills arrive.
- R10: A refill presented in the same cycle as `kmode_enter` is discarded.
- R11: `lk_paddr` is all zeros whenever `lk_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request qualifier |
| lk_vaddr | input | 48 | Virtual address to translate |
| lk_hit | output | 1 | Translation found (combinational) |
| lk_miss | output | 1 | Requested translation absent (combinational) |
| lk_paddr | output | 52 | Physical address on hit, zero otherwise |
| rf_valid | input | 1 | Refill write strobe |
| rf_vpn | input | 36 | Virtual page number being refilled |
| rf_ppn | input | 40 | Physical page number being refilled |
| kmode_enter | input | 1 | Switch into kernel mode: invalidate every entry |

## Verification
A corrupted valid flag, tag or page number shows up at the ports in the first cycle that a lookup addresses that entry. It appears either as a wrong hit/miss decision or as wrong bits in `lk_paddr[51:12]`. A wrong rotating pointer or a wrong empty-way choice stays hidden until a later refill evicts the wrong way. It then surfaces as a miss on a VPN that should still be resident, or a hit on one that should be gone. Because of this, the bench re-reads every resident VPN after each eviction. A failed flush or a failed discard of a colliding refill becomes visible one cycle later, as a hit where a miss is due.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VADDR_W   = 48;
    localparam int OFFSET_W  = 12;
    localparam int VPN_W     = VADDR_W - OFFSET_W;
    localparam int SET_IDX_W = 4;
    localparam int TAG_W     = VPN_W - SET_IDX_W;
    localparam int PPN_W     = 40;
    localparam int PADDR_W   = PPN_W + OFFSET_W;
    localparam int NUM_WAYS  = 4;
    localparam int WAY_IDX_W = $clog2(NUM_WAYS);
    localparam int NUM_SETS  = 1 << SET_IDX_W;

    typedef logic [VPN_W-1:0]     vpn_t;
    typedef logic [TAG_W-1:0]     tag_t;
    typedef logic [PPN_W-1:0]     ppn_t;
    typedef logic [SET_IDX_W-1:0] set_idx_t;
    typedef logic [WAY_IDX_W-1:0] way_idx_t;

    typedef struct packed {
        logic valid;
        tag_t tag;
        ppn_t ppn;
    } tlb_entry_t;

    typedef tlb_entry_t [NUM_WAYS-1:0] tlb_set_t;

    function automatic set_idx_t set_of(vpn_t v);
        return v[SET_IDX_W-1:0];
    endfunction

    function automatic tag_t tag_of(vpn_t v);
        return v[VPN_W-1:SET_IDX_W];
    endfunction

    function automatic vpn_t vpn_of(logic [VADDR_W-1:0] va);
        return va[VADDR_W-1:OFFSET_W];
    endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       wr_en,
    input  set_idx_t                   wr_set,
    input  way_idx_t                   wr_way,
    input  tag_t                       wr_tag,
    input  ppn_t                       wr_ppn,
    input  set_idx_t                   lk_set,
    output tlb_set_t                   lk_ways,
    input  set_idx_t                   rf_set,
    output logic [NUM_WAYS-1:0]        rf_valids,
    output tag_t [NUM_WAYS-1:0]        rf_tags
);
    tlb_set_t mem [NUM_SETS];

    // Flush and reset only drop valid flags; a flush wins over a write.
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    mem[s][w].valid <= 1'b0;
                end
            end
        end else if (wr_en) begin
            mem[wr_set][wr_way] <= '{valid: 1'b1, tag: wr_tag, ppn: wr_ppn};
        end
    end

    assign lk_ways = mem[lk_set];

    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            rf_valids[w] = mem[rf_set][w].valid;
            rf_tags[w]   = mem[rf_set][w].tag;
        end
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  logic [NUM_WAYS-1:0] valids,
    input  tag_t [NUM_WAYS-1:0] tags,
    input  tag_t                key,
    output logic                hit,
    output way_idx_t            way
);
    logic [NUM_WAYS-1:0] hit_vec;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valids[w] && (tags[w] == key);
    end

    always_comb begin
        hit = |hit_vec;
        way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (hit_vec[w]) way = way_idx_t'(w);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_WAYS-1:0] valids,
    input  set_idx_t            set_idx,
    input  logic                same_hit,
    input  way_idx_t            same_way,
    input  logic                commit,
    output way_idx_t            victim
);
    way_idx_t ptr [NUM_SETS];
    logic     free_found;
    way_idx_t free_way;

    // Lowest-numbered empty way.
    always_comb begin
        free_found = 1'b0;
        free_way   = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!valids[w]) begin
                free_found = 1'b1;
                free_way   = way_idx_t'(w);
            end
        end
    end

    always_comb begin
        if (same_hit)        victim = same_way;
        else if (free_found) victim = free_way;
        else                 victim = ptr[set_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) ptr[s] <= '0;
        end else if (commit && !same_hit && !free_found) begin
            ptr[set_idx] <= ptr[set_idx] + way_idx_t'(1);
        end
    end
endmodule

// File: rtl/tlb_sa.sv
module tlb_sa
    import tlb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    input  logic [VADDR_W-1:0] lk_vaddr,
    output logic               lk_hit,
    output logic               lk_miss,
    output logic [PADDR_W-1:0] lk_paddr,
    input  logic               rf_valid,
    input  logic [VPN_W-1:0]   rf_vpn,
    input  logic [PPN_W-1:0]   rf_ppn,
    input  logic               kmode_enter
);
    vpn_t                lk_vpn;
    tlb_set_t            lk_ways;
    logic [NUM_WAYS-1:0] lk_valids;
    tag_t [NUM_WAYS-1:0] lk_tags;
    logic                lk_found;
    way_idx_t            lk_way;

    logic [NUM_WAYS-1:0] rf_valids;
    tag_t [NUM_WAYS-1:0] rf_tags;
    logic                rf_same_hit;
    way_idx_t            rf_same_way;
    way_idx_t            rf_victim;
    logic                rf_commit;

    assign lk_vpn    = vpn_of(lk_vaddr);
    assign rf_commit = rf_valid && !kmode_enter;

    tlb_store u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (kmode_enter),
        .wr_en     (rf_commit),
        .wr_set    (set_of(rf_vpn)),
        .wr_way    (rf_victim),
        .wr_tag    (tag_of(rf_vpn)),
        .wr_ppn    (rf_ppn),
        .lk_set    (set_of(lk_vpn)),
        .lk_ways   (lk_ways),
        .rf_set    (set_of(rf_vpn)),
        .rf_valids (rf_valids),
        .rf_tags   (rf_tags)
    );

    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            lk_valids[w] = lk_ways[w].valid;
            lk_tags[w]   = lk_ways[w].tag;
        end
    end

    tlb_match u_lk_match (
        .valids (lk_valids),
        .tags   (lk_tags),
        .key    (tag_of(lk_vpn)),
        .hit    (lk_found),
        .way    (lk_way)
    );

    tlb_match u_rf_match (
        .valids (rf_valids),
        .tags   (rf_tags),
        .key    (tag_of(rf_vpn)),
        .hit    (rf_same_hit),
        .way    (rf_same_way)
    );

    tlb_victim u_victim (
        .clk      (clk),
        .rst      (rst),
        .valids   (rf_valids),
        .set_idx  (set_of(rf_vpn)),
        .same_hit (rf_same_hit),
        .same_way (rf_same_way),
        .commit   (rf_commit),
        .victim   (rf_victim)
    );

    assign lk_hit   = lk_valid && lk_found;
    assign lk_miss  = lk_valid && !lk_found;
    assign lk_paddr = lk_hit ? {lk_ways[lk_way].ppn, lk_vaddr[OFFSET_W-1:0]} : '0;
endmodule

// File: rtl/tlb_sa_checker.sv
module tlb_sa_checker
    import tlb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               lk_valid,
    input logic [VADDR_W-1:0] lk_vaddr,
    input logic               lk_hit,
    input logic               lk_miss,
    input logic [PADDR_W-1:0] lk_paddr,
    input logic               rf_valid,
    input logic [VPN_W-1:0]   rf_vpn,
    input logic [PPN_W-1:0]   rf_ppn,
    input logic               kmode_enter
);
    assert_one_answer_R3: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> $countones({lk_hit, lk_miss}) == 1);

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!lk_hit && !lk_miss));

    assert_offset_passes_R2: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_paddr[OFFSET_W-1:0] == lk_vaddr[OFFSET_W-1:0]);

    assert_miss_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> lk_paddr == '0);

    assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_hit);

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(kmode_enter)) |-> !lk_hit);

    assert_refill_visible_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(rf_valid && !kmode_enter) && lk_valid
         && vpn_of(lk_vaddr) == $past(rf_vpn))
        |-> (lk_hit && lk_paddr[PADDR_W-1:OFFSET_W] == $past(rf_ppn)));
endmodule

bind tlb_sa tlb_sa_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .lk_valid    (lk_valid),
    .lk_vaddr    (lk_vaddr),
    .lk_hit      (lk_hit),
    .lk_miss     (lk_miss),
    .lk_paddr    (lk_paddr),
    .rf_valid    (rf_valid),
    .rf_vpn      (rf_vpn),
    .rf_ppn      (rf_ppn),
    .kmode_enter (kmode_enter)
);

// File: tb/tlb_sa_tb.sv
module tlb_sa_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_vaddr = '0;
    logic        lk_hit, lk_miss;
    logic [51:0] lk_paddr;
    logic        rf_valid = 1'b0;
    logic [35:0] rf_vpn = '0;
    logic [39:0] rf_ppn = '0;
    logic        kmode_enter = 1'b0;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tlb_sa u_dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
        .kmode_enter(kmode_enter)
    );

    // Behavioural reference: resident translations per set, ordered by way slot.
    bit          m_v   [16][4];
    logic [31:0] m_tag [16][4];
    logic [39:0] m_ppn [16][4];
    int          m_ptr [16];

    function automatic void model_clear(bit all);
        for (int s = 0; s < 16; s++) begin
            for (int w = 0; w < 4; w++) m_v[s][w] = 0;
            if (all) m_ptr[s] = 0;
        end
    endfunction

    function automatic void model_refill(logic [35:0] vpn, logic [39:0] ppn);
        int s = int'(vpn[3:0]);
        int w = -1;
        for (int i = 0; i < 4; i++) if (w < 0 && m_v[s][i] && m_tag[s][i] == vpn[35:4]) w = i;
        for (int i = 0; i < 4; i++) if (w < 0 && !m_v[s][i]) w = i;
        if (w < 0) begin
            w = m_ptr[s];
            m_ptr[s] = (m_ptr[s] + 1) % 4;
        end
        m_v[s][w] = 1; m_tag[s][w] = vpn[35:4]; m_ppn[s][w] = ppn;
    endfunction

    task automatic step(input string req, input bit lv, input logic [47:0] va,
                        input bit rv, input logic [35:0] rvpn, input logic [39:0] rppn,
                        input bit inv);
        bit          e_hit = 0;
        logic [51:0] e_pa = '0;
        int          s;
        @(negedge clk);
        lk_valid = lv; lk_vaddr = va; rf_valid = rv; rf_vpn = rvpn; rf_ppn = rppn;
        kmode_enter = inv;
        #1;
        s = int'(va[15:12]);
        if (lv) for (int w = 0; w < 4; w++)
            if (m_v[s][w] && m_tag[s][w] == va[47:16]) begin
                e_hit = 1; e_pa = {m_ppn[s][w], va[11:0]};
            end
        compared++;
        if (lk_hit !== e_hit || lk_miss !== (lv && !e_hit) || lk_paddr !== e_pa) begin
            mismatched++;
            $display("FAIL %s: va=%h hit/miss/pa=%b/%b/%h expected %b/%b/%h", req, va,
                     lk_hit, lk_miss, lk_paddr, e_hit, lv && !e_hit, e_pa);
        end
        @(posedge clk);
        if (inv) model_clear(0);
        else if (rv) model_refill(rvpn, rppn);
    endtask

    function automatic logic [47:0] va_of(logic [31:0] tag, logic [3:0] set, logic [11:0] off);
        return {tag, set, off};
    endfunction

    task automatic look(input string req, input logic [31:0] tag, input logic [3:0] set);
        step(req, 1, va_of(tag, set, 12'h5a3 ^ tag[11:0]), 0, '0, '0, 0);
    endtask

    task automatic fill(input string req, input logic [31:0] tag, input logic [3:0] set,
                        input logic [39:0] ppn);
        step(req, 0, '0, 1, {tag, set}, ppn, 0);
    endtask

    initial begin
        model_clear(1);
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: empty after reset
        for (int i = 0; i < 4; i++) look("R1", 32'h100 + i, 4'(i));

        // R4, R2: refill then immediate lookup on the next cycle
        step("R4", 0, '0, 1, {32'hdead_0001, 4'h2}, 40'h12_3456_789a, 0);
        step("R4", 1, va_of(32'hdead_0001, 4'h2, 12'hfff), 0, '0, '0, 0);
        look("R2", 32'hdead_0002, 4'h2);          // same set, other tag: miss

        // R3: idle lookup while entry resident
        step("R3", 0, va_of(32'hdead_0001, 4'h2, 12'h001), 0, '0, '0, 0);

        // R5: same tag, different sets
        fill("R5", 32'h77, 4'h0, 40'haa);
        fill("R5", 32'h77, 4'h1, 40'hbb);
        look("R5", 32'h77, 4'h0);
        look("R5", 32'h77, 4'h1);
        look("R5", 32'h77, 4'h9);

        // R6 and R7: fill set 3, then round-robin replacement
        for (int t = 0; t < 4; t++) fill("R6", 32'h10 + t, 4'h3, 40'h1000 + t);
        for (int t = 0; t < 4; t++) look("R6", 32'h10 + t, 4'h3);
        fill("R7", 32'h14, 4'h3, 40'h2000);
        for (int t = 0; t < 5; t++) look("R7", 32'h10 + t, 4'h3);
        fill("R7", 32'h15, 4'h3, 40'h2001);
        for (int t = 0; t < 6; t++) look("R7", 32'h10 + t, 4'h3);

        // R8: refresh a resident tag in place
        fill("R8", 32'h13, 4'h3, 40'hfe_dcba_9876);
        for (int t = 2; t < 6; t++) look("R8", 32'h10 + t, 4'h3);
        fill("R8", 32'h16, 4'h3, 40'h3000);
        for (int t = 2; t < 7; t++) look("R8", 32'h10 + t, 4'h3);

        // R10 and R9: refill colliding with kernel entry, then everything misses
        step("R10", 0, '0, 1, {32'h99, 4'h4}, 40'h99, 1);
        look("R10", 32'h99, 4'h4);
        look("R9", 32'h77, 4'h0);
        look("R9", 32'h15, 4'h3);

        // R7: pointer survives invalidation (set 3 pointer is now 3)
        for (int t = 0; t < 4; t++) fill("R6", 32'h40 + t, 4'h3, 40'h4000 + t);
        fill("R7", 32'h44, 4'h3, 40'h5000);
        for (int t = 0; t < 5; t++) look("R7", 32'h40 + t, 4'h3);

        // R2, R11: mixed traffic over a small address pool
        for (int i = 0; i < 600; i++) begin
            logic [31:0] tg = 32'(($urandom % 6) + 32'h200);
            logic [3:0]  st = 4'($urandom % 3);
            step("R2", ($urandom % 4) != 0, va_of(tg, st, 12'($urandom)),
                 ($urandom % 3) == 0, {32'(($urandom % 6) + 32'h200), 4'($urandom % 3)},
                 40'($urandom), ($urandom % 97) == 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule